// File: doc/BRIEF.md
# Multicast Group-Code Message Router

This block takes a single stream of 64-bit control words and copies each word onto any subset of its serial output links. Every word carries a 16-bit destination group code. The code is translated through a downloadable membership table whose entries hold one enable bit per output link, so one word can reach one link, several links or all of them. A word whose code maps to no link is consumed, and a sticky flag records the event.

Each output link has its own transmit FIFO, which keeps the words bound for that link in arrival order. The input uses a ready/valid handshake. A holding stage keeps the most recently accepted word together with the membership bitmap it was looked up with. That stage waits until every selected link has room, so no word is ever dropped. The table is loaded through a separate write port. A write changes only the words accepted after it, never a word already held in the stage. The table depth is a parameter, so only the low part of the 65,536-code space needs storage. Codes beyond the table resolve to an empty membership.

Top module: `grp_msg_router`

## Requirements
- R1: The group code sits in bits [63:48] of the word. An accepted word is delivered unchanged on every link whose bit i is 1 in the table entry for its code, and on no other link. Bit i of an entry selects link i.
- R2: When `tbl_we` is high at a clock edge, `tbl_map` is stored for code `tbl_code`. A word accepted at that same edge still uses the previous entry, and words accepted at later edges use the new one.
- R3: On each link, words leave in the order they were accepted.
- R4: While the held word selects a link whose FIFO is full, `in_ready` is low and no further word is accepted. The held word is delivered once space appears, and no word is lost or overwritten.
- R5: A word whose entry is all zeros is consumed, appears on no link, and sets `unrouted`. The flag stays high until reset.
- R6: Codes at or above the table depth read as an all-zero entry, and table writes to such codes have no effect.
- R7: After reset, every table entry is zero, all FIFOs are empty, `unrouted` is low and `in_ready` is high.
- R8: While `lnk_valid[i]` is high and `lnk_ready[i]` is low, link i keeps its valid high and its data stable.
- R9: A word accepted at clock edge k, going to links whose FIFOs are empty, shows on those links right after edge k+1 and not before.
- R10: A full FIFO on a link that the held word does not select does not stall that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Router can take the offered word |
| in_msg | input | 64 | Input word, group code in [63:48] |
| tbl_we | input | 1 | Table write strobe |
| tbl_code | input | 16 | Group code whose entry is written |
| tbl_map | input | LINKS | Membership bitmap to store |
| lnk_valid | output | LINKS | Per-link word available |
| lnk_ready | input | LINKS | Per-link word taken by the serializer |
| lnk_data | output | LINKS*64 | Per-link head word, link i in bits [64*i+63:64*i] |
| unrouted | output | 1 | Sticky: a word matched no link |

## Verification
A table of group entries drives the lookup with a single-link map, a map on the top link only, a sparse alternating map, a broadcast map, an empty map and a code beyond the table depth. This tells a correct bit-to-link mapping apart from shifted or inverted enables, and separates the empty-membership path from out-of-range decoding. Directed patterns fill one link's FIFO with back-to-back words while another link keeps moving, to separate a correct stall from head-of-line blocking or loss. Those patterns then drain the full FIFO to show the order is kept. A word and a table write to the same code in the same cycle show whether the lookup uses the entry as it stood before the write.

// File: rtl/grpr_pkg.sv
package grpr_pkg;
   localparam int MSG_W    = 64;
   localparam int CODE_W   = 16;
   localparam int CODE_LSB = 48;

   typedef logic [MSG_W-1:0]  msg_t;
   typedef logic [CODE_W-1:0] code_t;

   function automatic code_t code_of(msg_t m);
      return m[CODE_LSB +: CODE_W];
   endfunction
endpackage

// File: rtl/grpr_table.sv
module grpr_table #(
   parameter int DEPTH  = 256,
   parameter int LINKS  = 8,
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CODE_W-1:0] waddr,
   input  logic [LINKS-1:0]  wmap,
   input  logic [CODE_W-1:0] raddr,
   output logic [LINKS-1:0]  rmap
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [LINKS-1:0] ent [DEPTH];
   logic             w_ok, r_ok;

   generate
      if (IDX_W < CODE_W) begin : g_partial
         assign w_ok = ~|waddr[CODE_W-1:IDX_W];
         assign r_ok = ~|raddr[CODE_W-1:IDX_W];
      end else begin : g_full
         assign w_ok = 1'b1;
         assign r_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      end else if (we && w_ok) begin
         ent[waddr[IDX_W-1:0]] <= wmap;
      end
   end

   assign rmap = r_ok ? ent[raddr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/grpr_stage.sv
module grpr_stage #(
   parameter int LINKS = 8,
   parameter int W     = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [W-1:0]     msg_in,
   input  logic [LINKS-1:0] map_in,
   input  logic [LINKS-1:0] full,
   output logic             room,
   output logic [W-1:0]     msg_out,
   output logic [LINKS-1:0] push,
   output logic             drop
);
   logic             held;
   logic [LINKS-1:0] held_map;
   logic             blocked, go;

   assign blocked = |(held_map & full);
   assign go      = held & ~blocked;
   assign room    = ~held | go;
   assign push    = go ? held_map : '0;
   assign drop    = go & ~|held_map;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held     <= 1'b0;
         held_map <= '0;
         msg_out  <= '0;
      end else begin
         if (cap) begin
            held     <= 1'b1;
            held_map <= map_in;
            msg_out  <= msg_in;
         end else if (go) begin
            held <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/grpr_fifo.sv
module grpr_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic         valid,
   output logic [W-1:0] dout
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign valid   = (cnt != '0);
   assign dout    = mem[rp];
   assign do_push = push & ~full;
   assign do_pop  = pop & valid;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/grp_msg_router.sv
module grp_msg_router
   import grpr_pkg::*;
#(
   parameter int LINKS     = 8,
   parameter int TBL_DEPTH = 256,
   parameter int FIFO_DEPTH = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [63:0]            in_msg,
   input  logic                   tbl_we,
   input  logic [15:0]            tbl_code,
   input  logic [LINKS-1:0]       tbl_map,
   output logic [LINKS-1:0]       lnk_valid,
   input  logic [LINKS-1:0]       lnk_ready,
   output logic [LINKS*64-1:0]    lnk_data,
   output logic                   unrouted
);
   generate
      if (LINKS < 1 || LINKS > 64) begin : g_bad_links
         $error("LINKS must be 1..64");
      end
      if (TBL_DEPTH < 2 || (TBL_DEPTH & (TBL_DEPTH - 1)) != 0 || TBL_DEPTH > (1 << CODE_W)) begin : g_bad_depth
         $error("TBL_DEPTH must be a power of two between 2 and the code space");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_fifo
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [LINKS-1:0] look_map;
   logic [LINKS-1:0] fifo_full;
   logic [LINKS-1:0] push;
   logic             drop;
   logic             accept;
   msg_t             held_msg;

   assign accept = in_valid & in_ready;

   grpr_table #(.DEPTH(TBL_DEPTH), .LINKS(LINKS), .CODE_W(CODE_W)) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .waddr (tbl_code),
      .wmap  (tbl_map),
      .raddr (code_of(in_msg)),
      .rmap  (look_map)
   );

   grpr_stage #(.LINKS(LINKS), .W(MSG_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (accept),
      .msg_in  (in_msg),
      .map_in  (look_map),
      .full    (fifo_full),
      .room    (in_ready),
      .msg_out (held_msg),
      .push    (push),
      .drop    (drop)
   );

   for (genvar i = 0; i < LINKS; i++) begin : g_link
      grpr_fifo #(.W(MSG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (push[i]),
         .din   (held_msg),
         .full  (fifo_full[i]),
         .pop   (lnk_ready[i]),
         .valid (lnk_valid[i]),
         .dout  (lnk_data[i*MSG_W +: MSG_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    unrouted <= 1'b0;
      else if (drop) unrouted <= 1'b1;
   end
endmodule

// File: rtl/grpr_router_chk.sv
module grpr_router_chk #(
   parameter int LINKS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [LINKS-1:0]    lnk_valid,
   input logic [LINKS-1:0]    lnk_ready,
   input logic [LINKS*64-1:0] lnk_data,
   input logic [LINKS-1:0]    push,
   input logic [LINKS-1:0]    fifo_full,
   input logic                unrouted
);
   for (genvar i = 0; i < LINKS; i++) begin : g_chk
      a_r4_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
         !(push[i] && fifo_full[i]));

      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (lnk_valid[i] && !lnk_ready[i]) |=>
            (lnk_valid[i] && $stable(lnk_data[i*64 +: 64])));
   end

   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      unrouted |=> unrouted);

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r7_reset_idle: assert (lnk_valid == '0 && !unrouted);
      end
   end
endmodule

bind grp_msg_router grpr_router_chk #(.LINKS(LINKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lnk_valid (lnk_valid),
   .lnk_ready (lnk_ready),
   .lnk_data  (lnk_data),
   .push      (push),
   .fifo_full (fifo_full),
   .unrouted  (unrouted)
);

// File: tb/tb_grp_msg_router.sv
module tb_grp_msg_router;
   localparam int L = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [63:0]       in_msg = '0;
   logic              tbl_we = 1'b0;
   logic [15:0]       tbl_code = '0;
   logic [L-1:0]      tbl_map = '0;
   logic [L-1:0]      lnk_valid;
   logic [L-1:0]      lnk_ready = '1;
   logic [L*64-1:0]   lnk_data;
   logic              unrouted;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   grp_msg_router dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_msg(in_msg), .tbl_we(tbl_we), .tbl_code(tbl_code), .tbl_map(tbl_map),
      .lnk_valid(lnk_valid), .lnk_ready(lnk_ready), .lnk_data(lnk_data),
      .unrouted(unrouted)
   );

   typedef struct packed {
      logic [15:0]  code;
      logic [L-1:0] wmap;
      logic [L-1:0] emap;
   } vec_t;

   // R1 mapping patterns, R5 empty entry, R6 code beyond the table
   localparam vec_t VEC [7] = '{
      '{16'h0004, 8'h00, 8'h00},
      '{16'h0001, 8'h01, 8'h01},
      '{16'h0002, 8'h80, 8'h80},
      '{16'h0003, 8'h5A, 8'h5A},
      '{16'h00FF, 8'hFF, 8'hFF},
      '{16'h1234, 8'h3C, 8'h00},
      '{16'h0006, 8'hA5, 8'hA5}
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic write_tbl(input logic [15:0] code, input logic [L-1:0] map);
      @(negedge clk);
      tbl_we = 1'b1; tbl_code = code; tbl_map = map;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // Drives one word; returns at the negedge after edge k+1
   task automatic send(input logic [63:0] m, input bit chk_lat);
      @(negedge clk);
      in_valid = 1'b1; in_msg = m;
      @(negedge clk);
      in_valid = 1'b0;
      if (chk_lat) check(lnk_valid == '0, "R9 early", 64'(lnk_valid), 64'h0);
      @(negedge clk);
   endtask

   function automatic logic [63:0] mk(input logic [15:0] code, input int n);
      return {code, 48'h0000_5EED_0000 ^ 48'(n * 32'h0101_0101)};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 64'h0, 64'h1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7 reset state
      check(in_ready == 1'b1, "R7 ready", 64'(in_ready), 64'h1);
      check(lnk_valid == '0, "R7 links", 64'(lnk_valid), 64'h0);
      check(unrouted == 1'b0, "R7 flag", 64'(unrouted), 64'h0);
      rst_n = 1'b1;

      // Table-driven walk: R1, R5, R6, R9
      for (int v = 0; v < 7; v++) begin
         logic [63:0] m;
         write_tbl(VEC[v].code, VEC[v].wmap);
         m = mk(VEC[v].code, v);
         send(m, 1'b1);
         check(lnk_valid == VEC[v].emap, "R1 enables", 64'(lnk_valid), 64'(VEC[v].emap));
         for (int i = 0; i < L; i++) begin
            if (VEC[v].emap[i])
               check(lnk_data[i*64 +: 64] == m, "R1 data", lnk_data[i*64 +: 64], m);
         end
         if (VEC[v].emap == '0)
            check(unrouted == 1'b1, "R5 flag set", 64'(unrouted), 64'h1);
      end
      check(unrouted == 1'b1, "R5 sticky", 64'(unrouted), 64'h1);

      // R2: same-edge write does not touch the word being accepted
      write_tbl(16'h0005, 8'h02);
      @(negedge clk);
      in_valid = 1'b1; in_msg = mk(16'h0005, 40);
      tbl_we = 1'b1; tbl_code = 16'h0005; tbl_map = 8'h04;
      @(negedge clk);
      in_valid = 1'b0; tbl_we = 1'b0;
      @(negedge clk);
      check(lnk_valid == 8'h02, "R2 old entry", 64'(lnk_valid), 64'h02);
      send(mk(16'h0005, 41), 1'b0);
      check(lnk_valid == 8'h04, "R2 new entry", 64'(lnk_valid), 64'h04);

      // R3/R4/R10: fill link 0, keep link 1 moving
      write_tbl(16'h000A, 8'h01);
      write_tbl(16'h000B, 8'h02);
      lnk_ready = '0;
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         in_valid = 1'b1; in_msg = mk(16'h000A, 100 + j);
      end
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check(lnk_valid[0] && lnk_data[63:0] == mk(16'h000A, 100), "R3 head", lnk_data[63:0], mk(16'h000A, 100));
      send(mk(16'h000B, 200), 1'b0);
      check(lnk_valid[1] == 1'b1, "R10 not stalled", 64'(lnk_valid), 64'h3);
      check(lnk_data[127:64] == mk(16'h000B, 200), "R10 data", lnk_data[127:64], mk(16'h000B, 200));
      @(negedge clk);
      in_valid = 1'b1; in_msg = mk(16'h000A, 104);
      @(negedge clk);
      in_msg = mk(16'h000A, 105);
      for (int k = 0; k < 3; k++) begin
         check(in_ready == 1'b0, "R4 stall", 64'(in_ready), 64'h0);
         check(lnk_data[63:0] == mk(16'h000A, 100), "R8 hold", lnk_data[63:0], mk(16'h000A, 100));
         @(negedge clk);
      end
      in_valid = 1'b0;
      lnk_ready = '1;
      for (int j = 1; j < 5; j++) begin
         @(negedge clk);
         check(lnk_valid[0] && lnk_data[63:0] == mk(16'h000A, 100 + j), "R3 order",
               lnk_data[63:0], mk(16'h000A, 100 + j));
      end
      @(negedge clk);
      check(lnk_valid[0] == 1'b0, "R4 no extra", 64'(lnk_valid), 64'h0);

      // R7: reset in the middle clears table and flag
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(unrouted == 1'b0 && in_ready == 1'b1, "R7 re-reset", 64'({unrouted, in_ready}), 64'h1);
      rst_n = 1'b1;
      send(mk(16'h0001, 300), 1'b0);
      check(lnk_valid == '0, "R7 table cleared", 64'(lnk_valid), 64'h0);
      check(unrouted == 1'b1, "R7 cleared entry unrouted", 64'(unrouted), 64'h1);

      finish_run();
   end
endmodule